// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block derives the three timing strobes of a video frame (vertical sync, horizontal sync and data enable) from a pixel clock, together with pixel column and row coordinates for a downstream pattern source. The frame shape comes entirely from count registers loaded by software. Every count is a number of pixel clocks. No resolution table is built in.

Vertical sync runs as an endless high/low train after an initial start delay. Each rising edge of vertical sync marks a frame start. At each frame start, the horizontal sync and data-enable trains are re-armed. Each of these trains waits its own delay measured from that edge, then issues a programmed number of high/low pulses, then stays low until the next frame start. A typical setup derives the counts from line and frame geometry:
- vertical high = sync lines × line length;
- data-enable delay = line length × (sync + back-porch lines) + horizontal sync + horizontal back porch;
- horizontal repeat = total lines;
- data-enable repeat = active lines.

All count registers are captured at frame start. Writes made during a frame therefore apply from the next frame.

Top module: `sync_timing_gen`

## Requirements
- R1: While `rst_n` is low, or on the clock after `en` is sampled low, `vs_o`, `hs_o`, `de_o`, `pix_x` and `pix_y` are all 0.
- R2: On the first clock with `en` sampled high after a low period, that cycle is t=0. `vs_o` first goes high at t = `vs_delay`. A delay of 0 makes `vs_o` high at t=0.
- R3: In each frame, `vs_o` is high for `vs_high` clocks and then low for `vs_low` clocks, so frames start every `vs_high`+`vs_low` clocks. Both counts must be nonzero.
- R4: `hs_o` first rises `hs_delay` clocks after a frame start. It then repeats `hs_high` clocks high and `hs_low` clocks low. After `hs_count` high pulses it stays low until the next frame start.
- R5: `de_o` behaves like R4, using `de_delay`, `de_high`, `de_low` and `de_count`.
- R6: A repeat count of 0 gives no pulse on that strobe for the whole frame.
- R7: A frame start re-arms the horizontal sync and data-enable trains even when their repeat counts are not yet used up. Any pulse train still in progress is abandoned.
- R8: `pix_x` is 0 on the first clock of each data-enable pulse. It increments by one on each further high clock, and is 0 whenever `de_o` is low.
- R9: `pix_y` is 0 from each frame start. It increments by one on the first low clock after each data-enable pulse.
- R10: The count registers apply to a frame only as sampled on its starting clock. The delay register applies as sampled on the first enabled clock. A change made mid-frame leaves the current frame unchanged.
- R11: Dropping `en` for any number of clocks and raising it again restarts the vertical delay count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears all state |
| vs_delay | input | LONG_W | Clocks from enable to first vertical sync rise |
| vs_high | input | LONG_W | Vertical sync high duration |
| vs_low | input | LONG_W | Vertical sync low duration |
| hs_delay | input | LONG_W | Frame start to first horizontal sync rise |
| de_delay | input | LONG_W | Frame start to first data-enable rise |
| hs_high | input | SHORT_W | Horizontal sync high clocks |
| hs_low | input | SHORT_W | Horizontal sync low clocks |
| hs_count | input | SHORT_W | Horizontal sync pulses per frame |
| de_high | input | SHORT_W | Data-enable high clocks (active width) |
| de_low | input | SHORT_W | Data-enable low clocks (blanking) |
| de_count | input | SHORT_W | Data-enable pulses per frame (active lines) |
| vs_o | output | 1 | Vertical sync strobe |
| hs_o | output | 1 | Horizontal sync strobe |
| de_o | output | 1 | Data-enable strobe |
| pix_x | output | SHORT_W | Pixel column within the active line |
| pix_y | output | SHORT_W | Active line index within the frame |

## Verification
The hardest situations to reach from the ports are two. In the first, a frame boundary arrives while a horizontal train still has pulses left. In the second, software rewrites the counts while the old values are still governing the current frame. The stimulus reaches the first by programming a repeat count larger than the lines that fit in a frame. It reaches the second by changing the data-enable widths at a chosen cycle inside the first frame. A cycle-accurate model in the bench, built from frame-relative arithmetic, then predicts every strobe and coordinate on every clock. Explicit counts of pulses and high cycles per frame confirm the old and new widths.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_WAIT = 3'd1,
      PH_HIGH = 3'd2,
      PH_LOW  = 3'd3,
      PH_DONE = 3'd4
   } phase_e;
endpackage

// File: rtl/vsg_shadow.sv
// Frame-start capture of count registers. eff_o shows the value that is in
// force this cycle: the live value on a load cycle, the held copy otherwise.
module vsg_shadow #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] live_i,
   output logic [W-1:0] eff_o,
   output logic [W-1:0] held_o
);
   initial assert (W >= 1) else $error("vsg_shadow: W must be positive");

   logic [W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= '0;
      else if (load) held_q <= live_i;
   end

   assign eff_o  = load ? live_i : held_q;
   assign held_o = held_q;
endmodule

// File: rtl/vsg_pulse_engine.sv
// Delay / high / low / repeat pulse engine. FINITE=0 builds an endless train
// (used for vertical sync); FINITE=1 stops after rpt high pulses.
module vsg_pulse_engine
   import vsg_pkg::*;
#(
   parameter int DLY_W  = 24,
   parameter int PER_W  = 16,
   parameter int RPT_W  = 16,
   parameter bit FINITE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start,
   input  logic [DLY_W-1:0] dly,
   input  logic [PER_W-1:0] hi,
   input  logic [PER_W-1:0] lo,
   input  logic [RPT_W-1:0] rpt,
   output logic             pulse_o,
   output logic             pulse_nxt_o,
   output logic             rise_nxt_o
);
   localparam int CNT_W = (DLY_W > PER_W) ? DLY_W : PER_W;

   initial assert (DLY_W >= 1 && PER_W >= 1 && RPT_W >= 1)
      else $error("vsg_pulse_engine: widths must be positive");

   phase_e           ph_q, ph_d;
   logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
   logic [RPT_W-1:0] pcnt_q, pcnt_d, pcnt_inc;
   logic [CNT_W-1:0] dly_x, hi_x, lo_x;
   logic             last_pulse, rpt_zero;

   assign cnt_inc  = cnt_q + CNT_W'(1);
   assign pcnt_inc = pcnt_q + RPT_W'(1);
   assign dly_x    = CNT_W'(dly);
   assign hi_x     = CNT_W'(hi);
   assign lo_x     = CNT_W'(lo);

   generate
      if (FINITE) begin : g_finite
         assign last_pulse = (pcnt_inc == rpt);
         assign rpt_zero   = (rpt == '0);
      end else begin : g_endless
         logic unused_rpt;
         assign unused_rpt = ^rpt;
         assign last_pulse = 1'b0;
         assign rpt_zero   = 1'b0;
      end
   endgenerate

   always_comb begin
      ph_d   = ph_q;
      cnt_d  = cnt_inc;
      pcnt_d = pcnt_q;
      if (!en) begin
         ph_d   = PH_IDLE;
         cnt_d  = '0;
         pcnt_d = '0;
      end else if (start) begin
         cnt_d  = '0;
         pcnt_d = '0;
         if (rpt_zero)        ph_d = PH_DONE;
         else if (dly_x == '0) ph_d = PH_HIGH;
         else                  ph_d = PH_WAIT;
      end else begin
         case (ph_q)
            PH_WAIT: begin
               if (cnt_inc == dly_x) begin
                  ph_d  = PH_HIGH;
                  cnt_d = '0;
               end
            end
            PH_HIGH: begin
               if (cnt_inc == hi_x) begin
                  cnt_d  = '0;
                  pcnt_d = pcnt_inc;
                  ph_d   = last_pulse ? PH_DONE : PH_LOW;
               end
            end
            PH_LOW: begin
               if (cnt_inc == lo_x) begin
                  ph_d  = PH_HIGH;
                  cnt_d = '0;
               end
            end
            default: cnt_d = cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         pcnt_q <= '0;
      end else begin
         ph_q   <= ph_d;
         cnt_q  <= cnt_d;
         pcnt_q <= pcnt_d;
      end
   end

   assign pulse_o     = (ph_q == PH_HIGH);
   assign pulse_nxt_o = (ph_d == PH_HIGH);
   assign rise_nxt_o  = (ph_d == PH_HIGH) && (ph_q != PH_HIGH);

   generate
      if (FINITE) begin : g_chk
         // a pulse in progress never exceeds the programmed repeat count
         assert_rpt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ph_q == PH_HIGH && !start) |-> (pcnt_q < rpt));
      end
   endgenerate
endmodule

// File: rtl/vsg_coord.sv
// Pixel column and active-line counters driven by the data-enable lookahead.
module vsg_coord #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         frame_nxt,
   input  logic         de_cur,
   input  logic         de_nxt,
   output logic [W-1:0] x_o,
   output logic [W-1:0] y_o
);
   initial assert (W >= 2) else $error("vsg_coord: W must be at least 2");

   logic [W-1:0] x_q, y_q, x_d, y_d;

   always_comb begin
      x_d = (en && de_nxt && de_cur && !frame_nxt) ? x_q + W'(1) : '0;
      if (!en || frame_nxt)        y_d = '0;
      else if (de_cur && !de_nxt)  y_d = y_q + W'(1);
      else                         y_d = y_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
      end else begin
         x_q <= x_d;
         y_q <= y_d;
      end
   end

   assign x_o = x_q;
   assign y_o = y_q;

   assert_x_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (de_cur && $past(de_cur) && !$past(frame_nxt)) |-> (x_q == $past(x_q) + W'(1)));

   assert_y_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(de_cur) && !de_cur && $past(en) && !$past(frame_nxt))
      |-> (y_q == $past(y_q) + W'(1)));
endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen #(
   parameter int LONG_W  = 24,
   parameter int SHORT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [LONG_W-1:0]  vs_delay,
   input  logic [LONG_W-1:0]  vs_high,
   input  logic [LONG_W-1:0]  vs_low,
   input  logic [LONG_W-1:0]  hs_delay,
   input  logic [LONG_W-1:0]  de_delay,
   input  logic [SHORT_W-1:0] hs_high,
   input  logic [SHORT_W-1:0] hs_low,
   input  logic [SHORT_W-1:0] hs_count,
   input  logic [SHORT_W-1:0] de_high,
   input  logic [SHORT_W-1:0] de_low,
   input  logic [SHORT_W-1:0] de_count,
   output logic               vs_o,
   output logic               hs_o,
   output logic               de_o,
   output logic [SHORT_W-1:0] pix_x,
   output logic [SHORT_W-1:0] pix_y
);
   localparam int N_LONG   = 5;
   localparam int N_SHORT  = 6;
   localparam int LONG_TW  = N_LONG * LONG_W;
   localparam int SHORT_TW = N_SHORT * SHORT_W;

   initial assert (SHORT_W >= 2 && SHORT_W <= LONG_W)
      else $error("sync_timing_gen: need 2 <= SHORT_W <= LONG_W");

   logic run_q, en_start, frame_nxt, load;
   logic vs_nxt, hs_nxt, de_nxt, hs_rise_unused, de_rise_unused;

   logic [LONG_TW-1:0]  long_live, long_eff, long_held;
   logic [SHORT_TW-1:0] short_live, short_eff, short_held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= en;
   end

   assign en_start = en && !run_q;
   assign load     = en_start || frame_nxt;

   assign long_live  = {vs_delay, vs_high, vs_low, hs_delay, de_delay};
   assign short_live = {hs_high, hs_low, hs_count, de_high, de_low, de_count};

   vsg_shadow #(.W(LONG_TW)) u_long_shadow (
      .clk(clk), .rst_n(rst_n), .load(load),
      .live_i(long_live), .eff_o(long_eff), .held_o(long_held)
   );

   vsg_shadow #(.W(SHORT_TW)) u_short_shadow (
      .clk(clk), .rst_n(rst_n), .load(load),
      .live_i(short_live), .eff_o(short_eff), .held_o(short_held)
   );

   // field views: index 0 is the most significant field of each vector
   logic [LONG_W-1:0]  lh [N_LONG];
   logic [LONG_W-1:0]  le [N_LONG];
   logic [SHORT_W-1:0] se [N_SHORT];

   generate
      for (genvar i = 0; i < N_LONG; i++) begin : g_long_view
         assign lh[i] = long_held[LONG_TW-1-i*LONG_W -: LONG_W];
         assign le[i] = long_eff [LONG_TW-1-i*LONG_W -: LONG_W];
      end
      for (genvar j = 0; j < N_SHORT; j++) begin : g_short_view
         assign se[j] = short_eff[SHORT_TW-1-j*SHORT_W -: SHORT_W];
      end
   endgenerate

   logic               unused_held;
   logic [LONG_W-1:0]  vs_dly_sel;
   assign unused_held = ^short_held ^ ^le[1] ^ ^le[2];
   // vertical timing never takes the frame-start load path: its own edge decides it
   assign vs_dly_sel  = en_start ? vs_delay : lh[0];

   vsg_pulse_engine #(
      .DLY_W(LONG_W), .PER_W(LONG_W), .RPT_W(SHORT_W), .FINITE(1'b0)
   ) u_vs (
      .clk(clk), .rst_n(rst_n), .en(en), .start(en_start),
      .dly(vs_dly_sel), .hi(lh[1]), .lo(lh[2]), .rpt('0),
      .pulse_o(vs_o), .pulse_nxt_o(vs_nxt), .rise_nxt_o(frame_nxt)
   );

   vsg_pulse_engine #(
      .DLY_W(LONG_W), .PER_W(SHORT_W), .RPT_W(SHORT_W), .FINITE(1'b1)
   ) u_hs (
      .clk(clk), .rst_n(rst_n), .en(en), .start(frame_nxt),
      .dly(le[3]), .hi(se[0]), .lo(se[1]), .rpt(se[2]),
      .pulse_o(hs_o), .pulse_nxt_o(hs_nxt), .rise_nxt_o(hs_rise_unused)
   );

   vsg_pulse_engine #(
      .DLY_W(LONG_W), .PER_W(SHORT_W), .RPT_W(SHORT_W), .FINITE(1'b1)
   ) u_de (
      .clk(clk), .rst_n(rst_n), .en(en), .start(frame_nxt),
      .dly(le[4]), .hi(se[3]), .lo(se[4]), .rpt(se[5]),
      .pulse_o(de_o), .pulse_nxt_o(de_nxt), .rise_nxt_o(de_rise_unused)
   );

   logic unused_nxt;
   assign unused_nxt = vs_nxt ^ hs_nxt ^ hs_rise_unused ^ de_rise_unused;

   vsg_coord #(.W(SHORT_W)) u_coord (
      .clk(clk), .rst_n(rst_n), .en(en), .frame_nxt(frame_nxt),
      .de_cur(de_o), .de_nxt(de_nxt), .x_o(pix_x), .y_o(pix_y)
   );

   assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!vs_o && !hs_o && !de_o && pix_x == '0 && pix_y == '0));

   assert_frame_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vs_o) |-> (pix_y == '0));

   assert_vs_resume_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(run_q) && vs_delay != '0 && $past(vs_delay) != '0) |-> !vs_o);
endmodule

// File: tb/sync_timing_gen_bench.sv
module sync_timing_gen_bench;
   localparam int LW = 24;
   localparam int SW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic [LW-1:0] c_vdly = '0, c_vh = '0, c_vl = '0, c_hd = '0, c_dd = '0;
   logic [SW-1:0] c_hh = '0, c_hl = '0, c_hn = '0, c_dh = '0, c_dl = '0, c_dn = '0;
   logic vs_o, hs_o, de_o;
   logic [SW-1:0] pix_x, pix_y;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sync_timing_gen #(.LONG_W(LW), .SHORT_W(SW)) u_sync_timing_gen (
      .clk(clk), .rst_n(rst_n), .en(en),
      .vs_delay(c_vdly), .vs_high(c_vh), .vs_low(c_vl),
      .hs_delay(c_hd), .de_delay(c_dd),
      .hs_high(c_hh), .hs_low(c_hl), .hs_count(c_hn),
      .de_high(c_dh), .de_low(c_dl), .de_count(c_dn),
      .vs_o(vs_o), .hs_o(hs_o), .de_o(de_o), .pix_x(pix_x), .pix_y(pix_y)
   );

   // model state: time since enable, current frame start and its counts
   int t = -1, tf = -1, nfs = 0;
   int f_vh, f_vl, f_hd, f_hh, f_hl, f_hn, f_dd, f_dh, f_dl, f_dn;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0d)", tag, what, act, exp, t);
      end
   endtask

   function automatic int pul(int r, int d, int hi, int lo, int n);
      int u;
      if (r < d) return 0;
      u = r - d;
      if (u / (hi + lo) >= n) return 0;
      return ((u % (hi + lo)) < hi) ? 1 : 0;
   endfunction

   function automatic int rowexp(int r, int d, int hi, int lo, int n);
      int u, k;
      if (r < d) return 0;
      u = r - d;
      k = u / (hi + lo);
      if (k >= n) return n;
      return k + (((u % (hi + lo)) >= hi) ? 1 : 0);
   endfunction

   // one clock: advance the model, then compare every output
   task automatic tick();
      int ev, eh, ed, ex, ey, r;
      @(negedge clk);
      if (en && rst_n) begin
         t++;
         if (t == 0) nfs = int'(c_vdly);
         if (t == nfs) begin
            f_vh = int'(c_vh); f_vl = int'(c_vl);
            f_hd = int'(c_hd); f_hh = int'(c_hh); f_hl = int'(c_hl); f_hn = int'(c_hn);
            f_dd = int'(c_dd); f_dh = int'(c_dh); f_dl = int'(c_dl); f_dn = int'(c_dn);
            tf = t;
            nfs = t + f_vh + f_vl;
         end
      end else begin
         t = -1;
         tf = -1;
      end
      ev = 0; eh = 0; ed = 0; ex = 0; ey = 0;
      if (tf >= 0) begin
         r  = t - tf;
         ev = (r < f_vh) ? 1 : 0;
         eh = pul(r, f_hd, f_hh, f_hl, f_hn);
         ed = pul(r, f_dd, f_dh, f_dl, f_dn);
         ex = ed ? ((r - f_dd) % (f_dh + f_dl)) : 0;
         ey = rowexp(r, f_dd, f_dh, f_dl, f_dn);
      end
      chk((tf < 0 && t >= 0) ? "R2" : "R3", "vs_o", int'(vs_o), ev);
      chk("R4", "hs_o", int'(hs_o), eh);
      chk("R5", "de_o", int'(de_o), ed);
      chk("R8", "pix_x", int'(pix_x), ex);
      chk("R9", "pix_y", int'(pix_y), ey);
   endtask

   task automatic run_count(input int n, output int vs_r, output int hs_r,
                            output int de_r, output int de_hi, output int max_x);
      logic pv, ph, pd;
      vs_r = 0; hs_r = 0; de_r = 0; de_hi = 0; max_x = 0;
      pv = vs_o; ph = hs_o; pd = de_o;
      for (int i = 0; i < n; i++) begin
         tick();
         if (vs_o && !pv) vs_r++;
         if (hs_o && !ph) hs_r++;
         if (de_o && !pd) de_r++;
         if (de_o) de_hi++;
         if (int'(pix_x) > max_x) max_x = int'(pix_x);
         pv = vs_o; ph = hs_o; pd = de_o;
      end
   endtask

   // small geometry: line = sync 2 + back porch 1 + active 4 + front porch 1 = 8
   // frame = sync 2 + back porch 1 + active 2 + front porch 1 = 6 lines
   task automatic load_basic();
      int hsw = 2, hbp = 1, hact = 4, hfp = 1, vsw = 2, vbp = 1, vact = 2, vfp = 1;
      int htot;
      htot = hsw + hbp + hact + hfp;
      c_vdly = LW'(3);
      c_vh = LW'(vsw * htot);
      c_vl = LW'((vact + vfp + vbp) * htot);
      c_hd = '0;
      c_hh = SW'(hsw);
      c_hl = SW'(hact + hfp + hbp);
      c_hn = SW'(vsw + vbp + vact + vfp);
      c_dd = LW'(htot * (vsw + vbp) + hsw + hbp);
      c_dh = SW'(hact);
      c_dl = SW'(htot - hact);
      c_dn = SW'(vact);
   endtask

   task automatic stop_and_check(input string tag);
      en = 1'b0;
      tick();
      chk(tag, "all strobes low after disable",
          int'(vs_o) + int'(hs_o) + int'(de_o) + int'(pix_x) + int'(pix_y), 0);
   endtask

   task automatic t_reset();
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R1", "outputs in reset",
             int'(vs_o) + int'(hs_o) + int'(de_o) + int'(pix_x) + int'(pix_y), 0);
      end
      rst_n = 1'b1;
      tick();
      chk("R1", "outputs idle with en low",
          int'(vs_o) + int'(hs_o) + int'(de_o) + int'(pix_x) + int'(pix_y), 0);
   endtask

   task automatic t_basic();
      int vr, hr, dr, dh, mx;
      load_basic();
      en = 1'b1;
      run_count(3 + 3 * 48, vr, hr, dr, dh, mx);
      chk("R3", "vs frames in three periods", vr, 3);
      chk("R4", "hs pulses in three frames", hr, 18);
      chk("R5", "de pulses in three frames", dr, 6);
      chk("R8", "largest column index", mx, 3);
      chk("R9", "row count at frame end", int'(pix_y), 2);
      stop_and_check("R1");
   endtask

   task automatic t_zero_delay();
      int vr, hr, dr, dh, mx;
      load_basic();
      c_vdly = '0;
      c_dd = '0;
      en = 1'b1;
      tick();
      chk("R2", "vs high on first enabled clock", int'(vs_o), 1);
      chk("R4", "hs high at frame start with zero delay", int'(hs_o), 1);
      chk("R5", "de high at frame start with zero delay", int'(de_o), 1);
      run_count(96, vr, hr, dr, dh, mx);
      stop_and_check("R1");
   endtask

   task automatic t_rpt_zero();
      int vr, hr, dr, dh, mx;
      load_basic();
      c_dn = '0;
      en = 1'b1;
      run_count(3 + 2 * 48, vr, hr, dr, dh, mx);
      chk("R6", "de high cycles with zero repeat", dh, 0);
      chk("R6", "row index with zero repeat", int'(pix_y), 0);
      stop_and_check("R1");
   endtask

   task automatic t_truncate();
      int vr, hr, dr, dh, mx;
      load_basic();
      c_hn = SW'(20);
      c_hd = LW'(4);
      en = 1'b1;
      run_count(3 + 2 * 48, vr, hr, dr, dh, mx);
      chk("R7", "hs pulses cut by frame restart", hr, 12);
      stop_and_check("R1");
   endtask

   task automatic t_midframe();
      int vr, hr, dr, dh1, dh2, mx;
      load_basic();
      en = 1'b1;
      run_count(13, vr, hr, dr, dh1, mx);
      c_dh = SW'(3);
      c_dl = SW'(5);
      run_count(51 - 13, vr, hr, dr, dh1, mx);
      chk("R10", "de high cycles in frame with mid-frame write", dh1, 8);
      chk("R10", "old width still governs column", mx, 3);
      run_count(48, vr, hr, dr, dh2, mx);
      chk("R10", "de high cycles in next frame", dh2, 6);
      chk("R10", "new width governs column", mx, 2);
      stop_and_check("R1");
   endtask

   task automatic t_restart();
      int vr, hr, dr, dh, mx;
      load_basic();
      en = 1'b1;
      run_count(20, vr, hr, dr, dh, mx);
      stop_and_check("R1");
      tick();
      tick();
      en = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R11", "vs low during restarted delay", int'(vs_o), 0);
      end
      tick();
      chk("R11", "vs rises after restarted delay", int'(vs_o), 1);
      run_count(60, vr, hr, dr, dh, mx);
      stop_and_check("R1");
   endtask

   initial begin
      t_reset();
      t_basic();
      t_zero_delay();
      t_rpt_zero();
      t_truncate();
      t_midframe();
      t_restart();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycles 200000 expected fewer");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule